// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether an incoming frame should be kept. It looks at the first six bytes of the frame, which hold the destination address. Those bytes arrive one per beat on a byte stream, and a start-of-frame flag marks the first of them. After the sixth byte the block gives a one-cycle verdict: accept or reject, together with a reason code. The verdict is built from a station address, a broadcast check, a 64-entry multicast hash filter and a promiscuous override. All of these rules are gated by a global receive enable.

The byte stream uses a valid/ready handshake. The filter never applies back-pressure: `in_ready` is low only during reset and high from the first clock after reset. A beat counts when `in_valid` and `in_ready` are both high. Idle cycles between beats are allowed and do not disturb the state. The configuration inputs are plain levels and are read in the cycle the verdict is shown.

Top module: `rx_dest_filter`

## Requirements
- R1: While reset is held, `in_ready` and `dec_valid` are low. From the first clock after reset, `in_ready` stays high.
- R2: A beat with `in_sof` set is address byte 0. The following accepted beats are bytes 1 to 5. `dec_valid` is high for exactly one cycle, in the cycle after the clock edge that takes byte 5. Beats after byte 5 are ignored until the next `in_sof`, and an `in_sof` always restarts the comparison from byte 0. Cycles with `in_valid` low are skipped without effect.
- R3: When `cfg_rx_en` is low, every verdict is a reject with reason 0.
- R4: When `cfg_rx_en` and `cfg_promisc` are both high, every verdict is an accept with reason 4 (promiscuous).
- R5: Local match uses the station words. Word k sits at bits [16k+15:16k] of `station_words`. Byte 2k must equal bits [16k+15:16k+8] and byte 2k+1 must equal bits [16k+7:16k]. A full match accepts with reason 1.
- R6: A destination whose six bytes are all 0xFF accepts with reason 2 (broadcast).
- R7: If `cfg_hash_en` is high and neither local nor broadcast matches, a CRC is run over the six bytes in arrival order. The CRC is reflected, uses polynomial 0xEDB88320, starts from 0xFFFFFFFF and is not inverted at the end. CRC bits [31:26] form an index i. The frame is accepted with reason 3 when `hash_table[i]` is 1, and rejected with reason 0 otherwise. Bits i[5:4] pick the 16-bit table word and i[3:0] pick the bit inside it.
- R8: With `cfg_hash_en` low, a frame that is neither local nor broadcast is rejected with reason 0.
- R9: Rules are checked in priority order: local, then broadcast, then hash. When `dec_valid` is high, `dec_accept` is 1 exactly when the reason is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Filter ready for a beat (high after reset) |
| in_sof | input | 1 | Beat is address byte 0 of a new frame |
| in_byte | input | 8 | Address byte |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_hash_en | input | 1 | Enable multicast hash filter |
| station_words | input | 48 | Station address as three 16-bit words |
| hash_table | input | 64 | Hash filter bits, indexed directly by the CRC index |
| dec_valid | output | 1 | Verdict strobe, one cycle |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 reject, 1 local, 2 broadcast, 3 hash, 4 promiscuous |

## Verification
Any internal error shows up only in the verdict cycle, one clock after byte 5 is taken. A slipped byte counter moves or drops the `dec_valid` pulse; the bench catches this on the very next frame because it samples at the exact expected cycle. A wrong CRC register or table lookup turns hash accepts into rejects for about half of the random multicast addresses. A stuck comparison flag flips local or broadcast verdicts. Gaps, restarts and extra trailing bytes are mixed in so that stale state from one frame leaks into the next verdict.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_LOCAL   = 3'd1,
    RSN_BCAST   = 3'd2,
    RSN_HASH    = 3'd3,
    RSN_PROMISC = 3'd4
  } reason_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  // one byte of a reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rdf_byte_seq.sv
module rdf_byte_seq #(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W = $clog2(ADDR_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  output logic             take,
  output logic             first,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;

  assign first = beat && sof;
  assign take  = beat && (sof || busy_q);
  assign idx   = sof ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        if (idx == IDX_W'(ADDR_BYTES - 1)) begin
          cnt_q  <= '0;
          busy_q <= 1'b0;
          done   <= 1'b1;
        end else begin
          cnt_q  <= idx + 1'b1;
          busy_q <= 1'b1;
        end
      end
    end
  end

  // R2: verdict strobe never lasts two cycles
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2: byte counter stays inside the address field
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < IDX_W'(ADDR_BYTES));
endmodule

// File: rtl/rdf_crc_acc.sv
module rdf_crc_acc #(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 first,
  input  logic [7:0]           data,
  output logic [HASH_BITS-1:0] hash_idx
);
  import rdf_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] base;

  assign base     = first ? CRC_SEED : crc_q;
  assign hash_idx = crc_q[31 -: HASH_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_step(base, data);
  end

  // R7: the running CRC only moves on an accepted address byte
  p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_q));
endmodule

// File: rtl/rdf_addr_match.sv
module rdf_addr_match #(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 16,
  localparam int IDX_W     = $clog2(ADDR_BYTES),
  localparam int BPW       = WORD_W / 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    first,
  input  logic [IDX_W-1:0]        idx,
  input  logic [7:0]              data,
  input  logic [ADDR_BYTES*8-1:0] station_words,
  output logic                    local_hit,
  output logic                    bcast_hit
);
  logic [7:0] stn_byte [ADDR_BYTES];

  // byte g of the address: high byte of its word comes first
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_stn
    assign stn_byte[g] = station_words[(g / BPW) * WORD_W + (BPW - 1 - (g % BPW)) * 8 +: 8];
  end

  logic loc_q, bc_q;
  assign local_hit = loc_q;
  assign bcast_hit = bc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= 1'b0;
      bc_q  <= 1'b0;
    end else if (take) begin
      loc_q <= (first || loc_q) && (data == stn_byte[idx]);
      bc_q  <= (first || bc_q) && (data == 8'hFF);
    end
  end

  // R5: a mismatched byte inside a frame cannot be undone by later bytes
  p_local_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !first && !loc_q |=> !loc_q);
  // R6: same for the broadcast flag
  p_bcast_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !first && !bc_q |=> !bc_q);
endmodule

// File: rtl/rdf_decide.sv
module rdf_decide #(
  parameter int HASH_BITS = 6,
  localparam int HT_W     = 1 << HASH_BITS
) (
  input  logic                 done,
  input  logic                 rx_en,
  input  logic                 promisc,
  input  logic                 hash_en,
  input  logic                 local_hit,
  input  logic                 bcast_hit,
  input  logic [HASH_BITS-1:0] hash_idx,
  input  logic [HT_W-1:0]      hash_table,
  output logic                 valid,
  output logic                 accept,
  output logic [2:0]           reason
);
  import rdf_pkg::*;

  reason_e rsn;

  always_comb begin
    if (!rx_en)                              rsn = RSN_NONE;
    else if (promisc)                        rsn = RSN_PROMISC;
    else if (local_hit)                      rsn = RSN_LOCAL;
    else if (bcast_hit)                      rsn = RSN_BCAST;
    else if (hash_en && hash_table[hash_idx]) rsn = RSN_HASH;
    else                                     rsn = RSN_NONE;
  end

  assign valid  = done;
  assign accept = done && (rsn != RSN_NONE);
  assign reason = done ? rsn : RSN_NONE;
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 16,
  parameter int HASH_BITS  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_sof,
  input  logic [7:0]                  in_byte,
  input  logic                        cfg_rx_en,
  input  logic                        cfg_promisc,
  input  logic                        cfg_hash_en,
  input  logic [ADDR_BYTES*8-1:0]     station_words,
  input  logic [(1<<HASH_BITS)-1:0]   hash_table,
  output logic                        dec_valid,
  output logic                        dec_accept,
  output logic [2:0]                  dec_reason
);
  localparam int IDX_W = $clog2(ADDR_BYTES);

  logic             rdy_q;
  logic             take, first, done, local_hit, bcast_hit;
  logic [IDX_W-1:0] idx;
  logic [HASH_BITS-1:0] hash_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q;

  rdf_byte_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .beat(in_valid && rdy_q), .sof(in_sof),
    .take(take), .first(first), .idx(idx), .done(done)
  );

  rdf_crc_acc #(.HASH_BITS(HASH_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .data(in_byte),
    .hash_idx(hash_idx)
  );

  rdf_addr_match #(.ADDR_BYTES(ADDR_BYTES), .WORD_W(WORD_W)) u_match (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .idx(idx),
    .data(in_byte), .station_words(station_words),
    .local_hit(local_hit), .bcast_hit(bcast_hit)
  );

  rdf_decide #(.HASH_BITS(HASH_BITS)) u_dec (
    .done(done), .rx_en(cfg_rx_en), .promisc(cfg_promisc), .hash_en(cfg_hash_en),
    .local_hit(local_hit), .bcast_hit(bcast_hit), .hash_idx(hash_idx),
    .hash_table(hash_table), .valid(dec_valid), .accept(dec_accept),
    .reason(dec_reason)
  );

  // R1: never back-pressures once out of reset
  p_ready_high_r1: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> in_ready);
  // R2: a verdict follows an accepted beat
  p_verdict_after_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));
  // R3: disabled receiver rejects
  p_disabled_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !cfg_rx_en |-> !dec_accept && dec_reason == 3'd0);
  // R4: promiscuous overrides the address rules
  p_promisc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && cfg_rx_en && cfg_promisc |-> dec_accept && dec_reason == 3'd4);
  // R9: accept flag agrees with the reason code
  p_reason_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_accept == (dec_reason != 3'd0));
  // R9: hash reason is impossible while the hash filter is off
  p_hash_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !cfg_hash_en |-> dec_reason != 3'd3);
endmodule

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_ready;
  logic        cfg_rx_en = 1'b1, cfg_promisc = 1'b0, cfg_hash_en = 1'b0;
  logic [47:0] station_words = '0;
  logic [63:0] hash_table = '0;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_reason;

  int checks = 0;
  int errors = 0;
  logic [7:0] cur [6];

  always #10 clk = ~clk;

  rx_dest_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_byte(in_byte), .cfg_rx_en(cfg_rx_en),
    .cfg_promisc(cfg_promisc), .cfg_hash_en(cfg_hash_en),
    .station_words(station_words), .hash_table(hash_table),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_index();
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      c = c ^ {24'd0, cur[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  // returns {accept, reason}
  function automatic logic [3:0] ref_verdict();
    bit loc = 1, bc = 1;
    for (int k = 0; k < 3; k++) begin
      if (station_words[16*k+8 +: 8] != cur[2*k])   loc = 0;
      if (station_words[16*k   +: 8] != cur[2*k+1]) loc = 0;
    end
    for (int i = 0; i < 6; i++) if (cur[i] != 8'hFF) bc = 0;
    if (!cfg_rx_en)                          return 4'h0;
    if (cfg_promisc)                         return 4'hC;
    if (loc)                                 return 4'h9;
    if (bc)                                  return 4'hA;
    if (cfg_hash_en && hash_table[ref_index()]) return 4'hB;
    return 4'h0;
  endfunction

  task automatic send_frame(input string req, input int gap_max, input int extra);
    logic [3:0] exp;
    exp = ref_verdict();
    for (int i = 0; i < 6; i++) begin
      int g = (gap_max > 0) ? int'($urandom % (gap_max + 1)) : 0;
      in_valid = 1'b0;
      for (int j = 0; j < g; j++) @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_byte = cur[i];
      @(negedge clk);
      if (i < 5) chk({req, " R2 no early verdict"}, dec_valid, 0);
    end
    in_valid = 1'b0; in_sof = 1'b0;
    chk({req, " R2 verdict strobe"}, dec_valid, 1);
    chk({req, " verdict"}, {dec_accept, dec_reason}, exp);
    for (int j = 0; j < extra; j++) begin
      in_valid = 1'b1; in_byte = 8'($urandom);
      @(negedge clk);
      chk("R2 trailing byte ignored", dec_valid, 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 single cycle strobe", dec_valid, 0);
  endtask

  task automatic load_station();
    for (int k = 0; k < 3; k++) begin
      cur[2*k] = station_words[16*k+8 +: 8]; cur[2*k+1] = station_words[16*k +: 8];
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 strobe low in reset", dec_valid, 0);
    chk("R1 ready low in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 1);

    station_words = 48'h0A1B_2C3D_4E5F;
    // R5 local exact, with gaps (R2)
    load_station();
    send_frame("R5 local", 2, 0);
    // R5 one byte off, hash off -> R8 reject
    cur[5] = cur[5] ^ 8'h01;
    send_frame("R8 near miss", 0, 0);
    // R6 broadcast, then trailing bytes
    for (int i = 0; i < 6; i++) cur[i] = 8'hFF;
    send_frame("R6 broadcast", 0, 3);
    // R3 disabled rejects broadcast
    cfg_rx_en = 1'b0;
    send_frame("R3 disabled", 1, 0);
    cfg_rx_en = 1'b1;
    // R9 station equal to broadcast -> local wins
    station_words = '1;
    send_frame("R9 priority local", 0, 0);
    // R4 promiscuous on random address
    station_words = 48'h0A1B_2C3D_4E5F;
    cfg_promisc = 1'b1;
    for (int i = 0; i < 6; i++) cur[i] = 8'($urandom);
    send_frame("R4 promisc", 0, 0);
    cfg_promisc = 1'b0;
    // R7 hash: only the target bit set, then all but it
    cur[0] = 8'h01; cur[1] = 8'h00; cur[2] = 8'h5E; cur[3] = 8'h12; cur[4] = 8'h34; cur[5] = 8'h56;
    cfg_hash_en = 1'b1;
    hash_table = 64'd1 << ref_index();
    send_frame("R7 hash hit", 0, 0);
    hash_table = ~(64'd1 << ref_index());
    send_frame("R7 hash miss", 0, 0);
    // R2 restart: aborted partial frame then broadcast
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_sof = (i == 0); in_byte = 8'h33;
      @(negedge clk);
    end
    for (int i = 0; i < 6; i++) cur[i] = 8'hFF;
    send_frame("R2 restart", 0, 0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int kind = int'($urandom % 4);
      cfg_rx_en   = ($urandom % 10) != 0;
      cfg_promisc = ($urandom % 5) == 0;
      cfg_hash_en = $urandom % 2;
      station_words = {16'($urandom), 32'($urandom)};
      hash_table = {32'($urandom), 32'($urandom)};
      case (kind)
        0: load_station();
        1: for (int i = 0; i < 6; i++) cur[i] = 8'hFF;
        2: begin
             for (int i = 0; i < 6; i++) cur[i] = 8'($urandom);
             cur[0][0] = 1'b1;
           end
        default: begin
             load_station();
             cur[$urandom % 6] ^= 8'h80;
           end
      endcase
      send_frame("R7 random", 2, int'($urandom % 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule